// File: doc/BRIEF.md
# Address-Hold DMA Transfer Sequencer

The sequencer moves a block of bytes from a source address to a destination address. It issues a paired read request and write request on a memory-request port that uses a valid/ready handshake. Only one request is outstanding at a time. When neither side is held, every pair moves one 32-byte line, and the last pair carries whatever is left over. Either side may instead be pinned to a fixed address, which is how a device data port is served. The pinned side then uses its own transaction size of 1, 2, 4 or 8 bytes for every pair, while the other side advances.

After each completed pair the sequencer keeps the memory port quiet for a programmable number of clocks. This gives another master a chance to win the shared bus.

A run is started with a one-cycle start pulse, and the configuration inputs are captured at that edge. An illegal configuration sets an error flag and moves nothing. A finished run produces a one-cycle done pulse. Both outcomes raise a completion interrupt, sent either to an internal active-high line or to an external active-low line.

Top module: `dma_hold_seq`

## Requirements
- R1: With neither hold set, each pair moves min(32, remaining) bytes (req_size). Both addresses advance by that size after each pair.
- R2: Each pair is a read at the source address (req_write=0), then a write at the destination address (req_write=1). While req_valid is high and req_ready is low, req_addr, req_write and req_size stay unchanged.
- R3: With source hold set, every read uses the captured source address. req_size is 1 << src_hsize (00=1, 01=2, 10=4, 11=8 bytes). The destination advances by that size.
- R4: With destination hold set, every write uses the captured destination address. req_size is 1 << dst_hsize, using the same encoding. The source advances by that size.
- R5: After each accepted write that is not the last, req_valid stays low for exactly 4 << gap_sel clocks (00=4, 01=8, 10=16, 11=32) before the next read. The first read appears in the cycle after the start edge.
- R6: A start is illegal when both holds are set, when the held address is not aligned to the hold size, or when byte_cnt is not a multiple of the hold size. An illegal start sets err in the next cycle and issues no request. A later legal start clears err.
- R7: done pulses for one cycle in the cycle after the final write is accepted. A start with byte_cnt = 0 pulses done in the next cycle and issues no request.
- R8: In the cycle where done pulses or err is set, the sequencer raises an interrupt. If irq_to_ext was 0 at start, irq_int is high for that cycle. If irq_to_ext was 1, irq_ext_n is low for that cycle. Both lines are idle at all other times.
- R9: A start pulse during a run is ignored. Addresses, sizes and count continue from the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled only when idle |
| src_addr | input | 32 | Source byte address |
| dst_addr | input | 32 | Destination byte address |
| byte_cnt | input | 16 | Bytes to move |
| src_hold | input | 1 | Pin the source address |
| dst_hold | input | 1 | Pin the destination address |
| src_hsize | input | 2 | Source hold size code |
| dst_hsize | input | 2 | Destination hold size code |
| gap_sel | input | 2 | Idle gap code |
| irq_to_ext | input | 1 | 1 sends the interrupt to irq_ext_n |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Request byte address |
| req_size | output | 6 | Request size in bytes |
| done | output | 1 | Run finished pulse |
| err | output | 1 | Illegal configuration flag |
| irq_int | output | 1 | Internal interrupt, active high |
| irq_ext_n | output | 1 | External interrupt, active low |

## Verification
Two events can fall in the same cycle: a new start pulse, and the memory port accepting a request during a run. The bench raises start, with a different source address on the inputs, in the very cycle it grants the first read. It then requires every later request to follow the originally captured addresses and sizes. The bench also stalls req_ready while a request is pending, and requires the held request to stay unchanged until the handshake completes.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;

    localparam int LINE_BYTES = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic       src_hold;
        logic       dst_hold;
        logic [1:0] src_hsize;
        logic [1:0] dst_hsize;
        logic [1:0] gap_sel;
        logic       irq_ext;
    } xfer_cfg_t;

    // bytes moved per pair for a hold size code
    function automatic logic [3:0] hold_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // quiet clocks after a pair for a gap code
    function automatic logic [5:0] gap_cycles(input logic [1:0] code);
        return 6'd4 << code;
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_hold_pkg::*;
(
    input  xfer_cfg_t  cfg,
    input  logic [3:0] src_lo,
    input  logic [3:0] dst_lo,
    input  logic [3:0] cnt_lo,
    output logic       illegal
);
    logic [3:0] mask;
    logic [3:0] held_lo;

    always_comb begin
        mask    = 4'd0;
        held_lo = 4'd0;
        if (cfg.src_hold) begin
            mask    = hold_bytes(cfg.src_hsize) - 4'd1;
            held_lo = src_lo;
        end else if (cfg.dst_hold) begin
            mask    = hold_bytes(cfg.dst_hsize) - 4'd1;
            held_lo = dst_lo;
        end
        illegal = (cfg.src_hold && cfg.dst_hold)
                || ((held_lo & mask) != 4'd0)
                || ((cnt_lo & mask) != 4'd0);
    end
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer
    import dma_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       last
);
    logic [5:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= 6'd0;
        else if (load)
            cnt <= gap_cycles(sel);
        else if (cnt != 6'd0)
            cnt <= cnt - 6'd1;
    end

    assign last = (cnt == 6'd1);

    // R5: a loaded gap is one of the four power-of-two lengths
    assert_gap_len_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> ($countones(cnt) == 1 && cnt >= 6'd4));

    assert_gap_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= 6'd32);
endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route (
    input  logic evt,
    input  logic to_ext,
    output logic irq_int,
    output logic irq_ext_n
);
    assign irq_int   = evt & ~to_ext;
    assign irq_ext_n = ~(evt & to_ext);
endmodule

// File: rtl/dma_hold_seq.sv
module dma_hold_seq
    import dma_hold_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] byte_cnt,
    input  logic          src_hold,
    input  logic          dst_hold,
    input  logic [1:0]    src_hsize,
    input  logic [1:0]    dst_hsize,
    input  logic [1:0]    gap_sel,
    input  logic          irq_to_ext,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output logic [$clog2(LINE_BYTES):0] req_size,
    output logic          done,
    output logic          err,
    output logic          irq_int,
    output logic          irq_ext_n
);
    localparam int SW = $clog2(LINE_BYTES) + 1;

    seq_state_e    state;
    xfer_cfg_t     cfg_in, cfg_q;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] rem_q;
    logic [SW-1:0] xsize;
    logic          done_q, err_q, evt_q;
    logic          illegal, gap_last, gap_load, last_pair;

    always_comb begin
        cfg_in.src_hold  = src_hold;
        cfg_in.dst_hold  = dst_hold;
        cfg_in.src_hsize = src_hsize;
        cfg_in.dst_hsize = dst_hsize;
        cfg_in.gap_sel   = gap_sel;
        cfg_in.irq_ext   = irq_to_ext;
    end

    dma_cfg_check u_check (
        .cfg    (cfg_in),
        .src_lo (src_addr[3:0]),
        .dst_lo (dst_addr[3:0]),
        .cnt_lo (byte_cnt[3:0]),
        .illegal(illegal)
    );

    always_comb begin
        if (cfg_q.src_hold)
            xsize = SW'(hold_bytes(cfg_q.src_hsize));
        else if (cfg_q.dst_hold)
            xsize = SW'(hold_bytes(cfg_q.dst_hsize));
        else if (rem_q < CW'(LINE_BYTES))
            xsize = rem_q[SW-1:0];
        else
            xsize = SW'(LINE_BYTES);
    end

    assign last_pair = (rem_q == CW'(xsize));
    assign gap_load  = (state == ST_WR) && req_ready && !last_pair;

    dma_gap_timer u_gap (
        .clk (clk),
        .rst (rst),
        .load(gap_load),
        .sel (cfg_q.gap_sel),
        .last(gap_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cfg_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            rem_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            evt_q  <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cfg_q <= cfg_in;
                    src_q <= src_addr;
                    dst_q <= dst_addr;
                    rem_q <= byte_cnt;
                    if (illegal) begin
                        err_q <= 1'b1;
                        evt_q <= 1'b1;
                    end else begin
                        err_q <= 1'b0;
                        if (byte_cnt == '0) begin
                            done_q <= 1'b1;
                            evt_q  <= 1'b1;
                        end else begin
                            state <= ST_RD;
                        end
                    end
                end
                ST_RD: if (req_ready) state <= ST_WR;
                ST_WR: if (req_ready) begin
                    if (!cfg_q.src_hold) src_q <= src_q + AW'(xsize);
                    if (!cfg_q.dst_hold) dst_q <= dst_q + AW'(xsize);
                    rem_q <= rem_q - CW'(xsize);
                    if (last_pair) begin
                        done_q <= 1'b1;
                        evt_q  <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_last) state <= ST_RD;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_valid = (state == ST_RD) || (state == ST_WR);
    assign req_write = (state == ST_WR);
    assign req_addr  = (state == ST_WR) ? dst_q : src_q;
    assign req_size  = xsize;
    assign done      = done_q;
    assign err       = err_q;

    dma_irq_route u_irq (
        .evt      (evt_q),
        .to_ext   (cfg_q.irq_ext),
        .irq_int  (irq_int),
        .irq_ext_n(irq_ext_n)
    );

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_write) && $stable(req_size)));

    assert_size_range_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_size != '0 && req_size <= SW'(LINE_BYTES)));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

    assert_err_noreq_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !req_valid);

    assert_irq_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_int, !irq_ext_n}));
endmodule

// File: tb/tb_dma_hold_seq.sv
module tb_dma_hold_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [15:0] byte_cnt = '0;
    logic        src_hold = 1'b0, dst_hold = 1'b0;
    logic [1:0]  src_hsize = '0, dst_hsize = '0, gap_sel = '0;
    logic        irq_to_ext = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid, req_write, done, err, irq_int, irq_ext_n;
    logic [31:0] req_addr;
    logic [5:0]  req_size;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_hold_seq dut (
        .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
        .byte_cnt(byte_cnt), .src_hold(src_hold), .dst_hold(dst_hold),
        .src_hsize(src_hsize), .dst_hsize(dst_hsize), .gap_sel(gap_sel),
        .irq_to_ext(irq_to_ext), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .done(done), .err(err), .irq_int(irq_int), .irq_ext_n(irq_ext_n)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] s, input logic [31:0] d, input logic [15:0] n,
                         input bit sh, input bit dh, input logic [1:0] shs, input logic [1:0] dhs,
                         input logic [1:0] gs, input bit ext);
        src_addr = s; dst_addr = d; byte_cnt = n; src_hold = sh; dst_hold = dh;
        src_hsize = shs; dst_hsize = dhs; gap_sel = gs; irq_to_ext = ext;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_irq(input string tag, input bit ext);
        if (ext) chk(irq_ext_n == 1'b0 && irq_int == 1'b0, {tag, " R8 external irq"}, {irq_int, irq_ext_n}, 2'b00);
        else     chk(irq_int == 1'b1 && irq_ext_n == 1'b1, {tag, " R8 internal irq"}, {irq_int, irq_ext_n}, 2'b11);
    endtask

    task automatic grant(input string tag, input logic [31:0] ea, input bit wr,
                         input logic [5:0] sz, input bit stall, input bit poke);
        chk(req_valid && req_write == wr && req_addr == ea && req_size == sz,
            $sformatf("%s request wr=%0d", tag, wr), {req_valid, req_write, req_size, req_addr},
            {1'b1, wr, sz, ea});
        if (stall) begin
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                chk(req_valid && req_write == wr && req_addr == ea && req_size == sz,
                    "R2 request held during stall", req_addr, ea);
            end
        end
        req_ready = 1'b1;
        if (poke) begin
            start = 1'b1;
            src_addr = 32'hDEAD_0000;
        end
        @(negedge clk);
        req_ready = 1'b0;
        start = 1'b0;
    endtask

    task automatic run_xfer(input string tag, input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] n, input bit sh, input bit dh,
                            input logic [1:0] shs, input logic [1:0] dhs, input logic [1:0] gs,
                            input bit ext, input bit stall, input bit poke);
        logic [31:0] es = s, ed = d;
        logic [15:0] rem = n;
        logic [5:0]  sz;
        bit          first = 1'b1;
        bit          pk = poke;
        int          gexp = 4 << gs;
        apply(s, d, n, sh, dh, shs, dhs, gs, ext);
        while (rem != 0) begin
            int idle = 0;
            sz = sh ? (6'd1 << shs) : dh ? (6'd1 << dhs) : (rem < 32 ? rem[5:0] : 6'd32);
            while (!req_valid && idle < 100) begin
                idle++;
                @(negedge clk);
            end
            chk(idle == (first ? 0 : gexp), {tag, " R5 idle gap before read"}, idle, first ? 0 : gexp);
            grant({tag, " read"}, es, 1'b0, sz, stall, pk);
            if (pk) src_addr = s;
            pk = 1'b0;
            grant({tag, " write"}, ed, 1'b1, sz, stall, 1'b0);
            rem = rem - 16'(sz);
            if (!sh) es = es + 32'(sz);
            if (!dh) ed = ed + 32'(sz);
            first = 1'b0;
        end
        chk(done == 1'b1 && !req_valid, {tag, " R7 done after last write"}, done, 1);
        check_irq(tag, ext);
        chk(err == 1'b0, {tag, " R6 err clear on legal run"}, err, 0);
        @(negedge clk);
        chk(done == 1'b0 && !req_valid && irq_int == 1'b0 && irq_ext_n == 1'b1,
            {tag, " R7 single done pulse"}, {done, req_valid, irq_int, irq_ext_n}, 4'b0001);
    endtask

    task automatic run_bad(input string tag, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input bit sh, input bit dh,
                           input logic [1:0] shs, input logic [1:0] dhs, input bit ext);
        bit quiet = 1'b1;
        apply(s, d, n, sh, dh, shs, dhs, 2'b00, ext);
        chk(err == 1'b1 && done == 1'b0, {tag, " R6 err set"}, {err, done}, 2'b10);
        check_irq(tag, ext);
        for (int k = 0; k < 12; k++) begin
            if (req_valid) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet && err == 1'b1, {tag, " R6 no request after illegal start"}, {quiet, err}, 2'b11);
    endtask

    task automatic run_zero();
        bit quiet = 1'b1;
        apply(32'h100, 32'h200, 16'd0, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0);
        chk(done == 1'b1 && !req_valid, "R7 zero count done", done, 1);
        check_irq("zero", 1'b0);
        for (int k = 0; k < 8; k++) begin
            if (req_valid) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet && done == 1'b0, "R7 zero count issues nothing", {quiet, done}, 2'b10);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!req_valid && !done && !err && !irq_int && irq_ext_n, "reset state",
            {req_valid, done, err, irq_int, irq_ext_n}, 5'b00001);
        run_xfer("R1 lines", 32'h1000, 32'h2000, 16'd100, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        run_xfer("R3 src hold", 32'h40, 32'h3000, 16'd16, 1'b1, 1'b0, 2'b10, 2'b00, 2'b01, 1'b1, 1'b1, 1'b0);
        run_xfer("R4/R9 dst hold", 32'h5000, 32'h88, 16'd24, 1'b0, 1'b1, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0, 1'b1);
        run_xfer("R4 byte hold", 32'h6000, 32'h7, 16'd3, 1'b0, 1'b1, 2'b00, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0);
        run_xfer("R3 pair hold", 32'h22, 32'h7000, 16'd4, 1'b1, 1'b0, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        run_bad("both holds", 32'h0, 32'h0, 16'd8, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0);
        run_bad("misaligned src", 32'h42, 32'h100, 16'd8, 1'b1, 1'b0, 2'b10, 2'b00, 1'b1);
        run_bad("odd count", 32'h100, 32'h10, 16'd10, 1'b0, 1'b1, 2'b00, 2'b11, 1'b0);
        run_xfer("R6 recover", 32'h100, 32'h200, 16'd8, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        run_zero();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule